// File: doc/BRIEF.md
# Maskable Interrupt Controller

This block collects ten single-cycle event pulses from line-monitoring and timer resources into per-source pending bits. Each pending bit has a matching active-high enable bit. A pending bit is set only when its event arrives while its enable is high. Software clears pending bits one at a time by writing 1 to them. Pending bits and enable bits are split across three narrow status registers and three narrow enable registers.

The interrupt output is modelled as the enable of an open-drain pull-down. It is high, meaning the shared line is pulled low, for as long as any pending bit is set. Software sees a small synchronous register port with a write strobe, a read strobe, an address and write data. Read data is registered.

Source order, from source index 0 upward: loop current or ring ground, ring trip, power alarm, active timer 1, inactive timer 1, active timer 2, inactive timer 2, ringing active timer, ringing inactive timer, indirect access complete. Source index i sits in register i/4, at bit i%4.

Top module: `irq_ctrl_top`

## Requirements
- R1: A synchronous active-high `rst` clears every pending bit, every enable bit, `irq_oe` and `rd_data`.
- R2: An event on a source whose enable bit is 0 leaves that source's pending bit unchanged.
- R3: An event on a source whose enable bit is 1 sets that source's pending bit at the next clock edge. Source i is bit i%4 of status register i/4.
- R4: Writing a status register clears each pending bit whose `wdata` bit is 1. Bits written as 0 keep their value.
- R5: If an event on an enabled source arrives in the same cycle as a write-1 clear of its pending bit, the bit stays set.
- R6: `irq_oe` is 1 exactly when at least one pending bit is set. It follows the pending bits after the same clock edge.
- R7: Writing an enable register stores `wdata` into the enable bits for its sources. A register bit with no source behind it reads 0, whatever value was written to it.
- R8: Address encoding: `addr[2]`=0 selects status register `addr[1:0]`, and `addr[2]`=1 selects enable register `addr[1:0]`. Index 3 reads 0 and writes to it are ignored. When `rd_en` is 1, `rd_data` takes the addressed register's value from before that clock edge. When `rd_en` is 0, `rd_data` holds its value.
- R9: Clearing an enable bit does not clear a pending bit that is already set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| evt_i | input | 10 | Event pulses, one per source |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | 3 | Bank select (bit 2) and register index (bits 1:0) |
| wdata | input | 4 | Write data |
| rd_data | output | 4 | Registered read data |
| irq_oe | output | 1 | High while the interrupt line is to be pulled low |

## Verification
The assertions assume three things about the inputs. Each event is a level that is sampled on every clock edge. `wr_en` and `rd_en` are sampled only at clock edges. `addr` may select the unused index 3. The stimulus drives every input just after a falling edge, so each value is stable across the next rising edge. Directed phases cover each requirement, including an event and a clear in the same cycle. A random phase then sends events, clears, enable writes and reads to every address, including index 3, at any time, with no protocol between them.

// File: rtl/irq_pkg.sv
package irq_pkg;
  typedef enum logic {BANK_STATUS = 1'b0, BANK_ENABLE = 1'b1} bank_e;

  function automatic int idx_bits(input int n);
    return (n <= 2) ? 1 : $clog2(n);
  endfunction

  function automatic int ceil_div(input int a, input int b);
    return (a + b - 1) / b;
  endfunction
endpackage

// File: rtl/irq_reg_decode.sv
module irq_reg_decode #(
  parameter int N_SRC = 10,
  parameter int REG_W = 4,
  parameter int N_REG = 3,
  parameter int IDX_W = 2
) (
  input  logic             wr_en,
  input  logic [IDX_W:0]   addr,
  input  logic [REG_W-1:0] wdata,
  output logic [N_SRC-1:0] clr,
  output logic [N_SRC-1:0] en_we,
  output logic [N_SRC-1:0] en_wd
);
  import irq_pkg::*;
  logic [N_REG-1:0] st_sel;
  logic [N_REG-1:0] en_sel;

  for (genvar r = 0; r < N_REG; r++) begin : g_reg
    logic hit;
    assign hit       = (addr[IDX_W-1:0] == IDX_W'(r));
    assign st_sel[r] = wr_en && hit && (bank_e'(addr[IDX_W]) == BANK_STATUS);
    assign en_sel[r] = wr_en && hit && (bank_e'(addr[IDX_W]) == BANK_ENABLE);
  end

  for (genvar b = 0; b < N_SRC; b++) begin : g_bit
    assign clr[b]   = st_sel[b / REG_W] & wdata[b % REG_W];
    assign en_we[b] = en_sel[b / REG_W];
    assign en_wd[b] = wdata[b % REG_W];
  end
endmodule

// File: rtl/irq_enable_bank.sv
module irq_enable_bank #(
  parameter int N_SRC = 10
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [N_SRC-1:0] en_we,
  input  logic [N_SRC-1:0] en_wd,
  output logic [N_SRC-1:0] en
);
  for (genvar b = 0; b < N_SRC; b++) begin : g_en
    always_ff @(posedge clk) begin
      if (rst)          en[b] <= 1'b0;
      else if (en_we[b]) en[b] <= en_wd[b];
    end
  end

  AST_EN_WRITE_TAKES: assert property (@(posedge clk) disable iff (rst)
    !rst |=> (((en ^ $past(en_wd)) & $past(en_we)) == '0)); // R7
  AST_EN_HOLDS: assert property (@(posedge clk) disable iff (rst)
    !rst |=> (((en ^ $past(en)) & ~$past(en_we)) == '0)); // R7
endmodule

// File: rtl/irq_status_bank.sv
module irq_status_bank #(
  parameter int N_SRC = 10
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [N_SRC-1:0] evt,
  input  logic [N_SRC-1:0] en,
  input  logic [N_SRC-1:0] clr,
  output logic [N_SRC-1:0] st,
  output logic             irq_q
);
  logic [N_SRC-1:0] set_v;
  logic [N_SRC-1:0] st_nxt;

  always_comb begin
    set_v  = evt & en;
    st_nxt = (st & ~clr) | set_v;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st    <= '0;
      irq_q <= 1'b0;
    end else begin
      st    <= st_nxt;
      irq_q <= |st_nxt;
    end
  end

  AST_SET_WHEN_ENABLED: assert property (@(posedge clk) disable iff (rst)
    !rst |=> ((st & $past(evt & en)) == $past(evt & en))); // R3
  AST_NO_SET_DISABLED: assert property (@(posedge clk) disable iff (rst)
    !rst |=> ((st & ~$past(st) & ~$past(evt & en)) == '0)); // R2
  AST_CLEAR_ONLY_BY_WRITE: assert property (@(posedge clk) disable iff (rst)
    !rst |=> ((~st & $past(st) & ~$past(clr)) == '0)); // R9
endmodule

// File: rtl/irq_read_mux.sv
module irq_read_mux #(
  parameter int N_SRC = 10,
  parameter int REG_W = 4,
  parameter int N_REG = 3,
  parameter int IDX_W = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             rd_en,
  input  logic [IDX_W:0]   addr,
  input  logic [N_SRC-1:0] st,
  input  logic [N_SRC-1:0] en,
  output logic [REG_W-1:0] rd_data
);
  localparam int W = N_REG * REG_W;
  logic [W-1:0]     st_w;
  logic [W-1:0]     en_w;
  logic [REG_W-1:0] sel;

  for (genvar b = 0; b < W; b++) begin : g_pad
    if (b < N_SRC) begin : g_impl
      assign st_w[b] = st[b];
      assign en_w[b] = en[b];
    end else begin : g_none
      assign st_w[b] = 1'b0;
      assign en_w[b] = 1'b0;
    end
  end

  always_comb begin
    sel = '0;
    for (int r = 0; r < N_REG; r++) begin
      if (addr[IDX_W-1:0] == IDX_W'(r))
        sel = addr[IDX_W] ? en_w[r*REG_W +: REG_W] : st_w[r*REG_W +: REG_W];
    end
  end

  always_ff @(posedge clk) begin
    if (rst)        rd_data <= '0;
    else if (rd_en) rd_data <= sel;
  end

  AST_RD_HOLD: assert property (@(posedge clk) disable iff (rst)
    !rd_en |=> $stable(rd_data)); // R8
endmodule

// File: rtl/irq_ctrl_top.sv
module irq_ctrl_top #(
  parameter int N_SRC = 10,
  parameter int REG_W = 4,
  localparam int N_REG  = irq_pkg::ceil_div(N_SRC, REG_W),
  localparam int IDX_W  = irq_pkg::idx_bits(N_REG),
  localparam int ADDR_W = IDX_W + 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [N_SRC-1:0]  evt_i,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [REG_W-1:0]  wdata,
  output logic [REG_W-1:0]  rd_data,
  output logic              irq_oe
);
  logic [N_SRC-1:0] clr;
  logic [N_SRC-1:0] en_we;
  logic [N_SRC-1:0] en_wd;
  logic [N_SRC-1:0] en;
  logic [N_SRC-1:0] st;

  irq_reg_decode #(.N_SRC(N_SRC), .REG_W(REG_W), .N_REG(N_REG), .IDX_W(IDX_W)) u_dec (
    .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .clr(clr), .en_we(en_we), .en_wd(en_wd));

  irq_enable_bank #(.N_SRC(N_SRC)) u_en (
    .clk(clk), .rst(rst), .en_we(en_we), .en_wd(en_wd), .en(en));

  irq_status_bank #(.N_SRC(N_SRC)) u_st (
    .clk(clk), .rst(rst), .evt(evt_i), .en(en), .clr(clr),
    .st(st), .irq_q(irq_oe));

  irq_read_mux #(.N_SRC(N_SRC), .REG_W(REG_W), .N_REG(N_REG), .IDX_W(IDX_W)) u_rd (
    .clk(clk), .rst(rst), .rd_en(rd_en), .addr(addr),
    .st(st), .en(en), .rd_data(rd_data));

  AST_IRQ_TRACKS_STATUS: assert property (@(posedge clk) disable iff (rst)
    irq_oe == (st != '0)); // R6
  AST_SET_BEATS_CLEAR: assert property (@(posedge clk) disable iff (rst)
    ((evt_i & en & clr) != '0) |=> irq_oe); // R5
endmodule

// File: tb/irq_ctrl_top_tb_top.sv
`timescale 1ns/1ps
module irq_ctrl_top_tb_top;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [9:0] evt_i = '0;
  logic       wr_en = 1'b0, rd_en = 1'b0;
  logic [2:0] addr = '0;
  logic [3:0] wdata = '0;
  logic [3:0] rd_data;
  logic       irq_oe;

  int checks = 0, errors = 0;
  logic       run_cmp = 1'b0;

  // reference model state
  logic [11:0] m_st = '0, m_en = '0;
  logic [3:0]  m_rd = '0;
  logic        m_irq = 1'b0;

  always #10 clk = ~clk;

  irq_ctrl_top dut_i (.clk(clk), .rst(rst), .evt_i(evt_i), .wr_en(wr_en),
    .rd_en(rd_en), .addr(addr), .wdata(wdata), .rd_data(rd_data), .irq_oe(irq_oe));

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  always @(posedge clk) begin
    logic [11:0] ns, ne;
    if (rst) begin
      m_st = '0; m_en = '0; m_rd = '0; m_irq = 1'b0;
    end else begin
      ns = m_st; ne = m_en;
      if (rd_en)
        m_rd = (addr[1:0] == 2'd3) ? 4'h0 : (addr[2] ? m_en[addr[1:0]*4 +: 4] : m_st[addr[1:0]*4 +: 4]);
      if (wr_en && addr[1:0] != 2'd3) begin
        for (int j = 0; j < 4; j++) begin
          if (!addr[2] && wdata[j]) ns[addr[1:0]*4 + j] = 1'b0;
          if (addr[2]) ne[addr[1:0]*4 + j] = wdata[j];
        end
      end
      for (int i = 0; i < 10; i++)
        if (evt_i[i] && m_en[i]) ns[i] = 1'b1;
      ne[11:10] = 2'b00;
      m_st = ns; m_en = ne; m_irq = (ns != 0);
    end
  end

  always @(negedge clk) begin
    if (run_cmp) begin
      check("R6 irq_oe vs model", int'(irq_oe), int'(m_irq));
      check("R8 rd_data vs model", int'(rd_data), int'(m_rd));
    end
  end

  task automatic idle(input int n);
    for (int k = 0; k < n; k++) @(negedge clk);
  endtask

  task automatic wr(input logic [2:0] a, input logic [3:0] d);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0; wdata = '0;
  endtask

  task automatic rd_chk(input logic [2:0] a, input logic [3:0] exp, input string req);
    rd_en = 1'b1; addr = a;
    @(negedge clk);
    rd_en = 1'b0;
    check(req, int'(rd_data), int'(exp));
  endtask

  task automatic pulse(input logic [9:0] e);
    evt_i = e;
    @(negedge clk);
    evt_i = '0;
  endtask

  initial begin
    #(200000 * 20);
    errors++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    @(negedge clk);
    rst = 1'b1;
    idle(4);
    check("R1 reset irq_oe", int'(irq_oe), 0);
    check("R1 reset rd_data", int'(rd_data), 0);
    rst = 1'b0;
    run_cmp = 1'b1;
    for (int r = 0; r < 3; r++) rd_chk(3'(r), 4'h0, "R1 status zero after reset");
    for (int r = 0; r < 3; r++) rd_chk(3'(4 + r), 4'h0, "R1 enable zero after reset");

    pulse(10'h3FF);
    for (int r = 0; r < 3; r++) rd_chk(3'(r), 4'h0, "R2 disabled events ignored");
    check("R2 irq_oe stays low", int'(irq_oe), 0);

    wr(3'd4, 4'hF); wr(3'd5, 4'h5); wr(3'd6, 4'hF);
    rd_chk(3'd6, 4'h3, "R7 unbacked enable bits read 0");
    rd_chk(3'd5, 4'h5, "R7 enable readback");
    wr(3'd3, 4'hF); wr(3'd7, 4'hF);
    rd_chk(3'd3, 4'h0, "R8 index 3 status reads 0");
    rd_chk(3'd7, 4'h0, "R8 index 3 enable reads 0");

    pulse(10'b10_0000_0001);
    rd_chk(3'd0, 4'h1, "R3 source 0 -> reg0 bit0");
    rd_chk(3'd2, 4'h2, "R3 source 9 -> reg2 bit1");
    check("R6 irq_oe high when pending", int'(irq_oe), 1);

    wr(3'd0, 4'h0);
    rd_chk(3'd0, 4'h1, "R4 write 0 keeps bit");
    wr(3'd0, 4'h1);
    rd_chk(3'd0, 4'h0, "R4 write 1 clears bit");
    check("R6 irq_oe held by remaining bit", int'(irq_oe), 1);
    wr(3'd2, 4'h2);
    check("R6 irq_oe low when all clear", int'(irq_oe), 0);

    pulse(10'b00_0010_0000);
    rd_chk(3'd1, 4'h0, "R2 source 5 disabled");
    pulse(10'b00_0001_0000);
    rd_chk(3'd1, 4'h1, "R3 source 4 -> reg1 bit0");

    evt_i = 10'b00_0001_0000;
    wr(3'd1, 4'h1);
    evt_i = '0;
    rd_chk(3'd1, 4'h1, "R5 set wins over clear");

    wr(3'd5, 4'h0);
    rd_chk(3'd1, 4'h1, "R9 disable keeps pending");
    check("R9 irq_oe still high", int'(irq_oe), 1);
    wr(3'd1, 4'hF);
    rd_chk(3'd1, 4'h0, "R4 clear after disable");

    wr(3'd4, 4'hA);
    rd_chk(3'd4, 4'hA, "R8 read captures value");
    wr(3'd4, 4'h3);
    idle(3);
    check("R8 rd_data held without rd_en", int'(rd_data), 32'hA);

    for (int k = 0; k < 400; k++) begin
      evt_i = 10'($urandom) & 10'($urandom);
      wr_en = ($urandom % 3) == 0;
      rd_en = ($urandom % 2) == 0;
      addr  = 3'($urandom);
      wdata = 4'($urandom);
      @(negedge clk);
    end
    evt_i = '0; wr_en = 1'b0; rd_en = 1'b0;
    idle(2);

    rst = 1'b1;
    idle(2);
    rst = 1'b0;
    check("R1 mid-run reset irq_oe", int'(irq_oe), 0);
    rd_chk(3'd4, 4'h0, "R1 enable cleared by reset");

    run_cmp = 1'b0;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule